// File: doc/BRIEF.md
# Byte/Word ALU with Status Flags

This block is the arithmetic and logic stage of a small integer datapath. Each cycle it takes two operands, an operation code and a width select. It returns a result and a six-bit status vector in the same cycle, with no register in the path. The width select picks either an 8-bit byte or a 16-bit word. Both the result and the flags follow that width. Operands can be read as signed or unsigned: carry reports unsigned range and overflow reports signed range.

A flag register sits beside the datapath. It loads the computed flags when the write enable is high and keeps its value otherwise. Some operations read it back: increment and decrement keep the stored carry, rotates through carry take their incoming bit from it, and plain rotates keep the stored parity, auxiliary, zero and sign bits.

All shifts and rotates move the operand by exactly one bit position.

Top module: `bw_alu`

## Requirements
- R1: When `word_i` is 0, only operand bits 7:0 are used, the result is formed in bits 7:0, and result bits 15:8 are 0. When `word_i` is 1, all 16 bits are used.
- R2: Flag vector layout is bit 0 carry, bit 1 parity, bit 2 auxiliary carry, bit 3 zero, bit 4 sign, bit 5 overflow. Sign is the top bit of the selected width. Zero is set when every bit of the selected width is 0. Parity is set when bits 7:0 hold an even number of ones.
- R3: ADD (op 0) gives A+B. Carry is the carry out of the selected width, auxiliary carry is the carry out of bit 3, and overflow flags a signed result out of range.
- R4: SUB (op 1) gives A-B. Carry is the borrow out of the width and auxiliary carry is the borrow out of bit 3. CMP (op 9) produces the same flags as SUB, but its result output shows A unchanged.
- R5: AND (op 2), OR (op 3), XOR (op 4) and NOT (op 5, inverts A) act bitwise. Each clears carry, auxiliary carry and overflow.
- R6: INC (op 6) gives A+1 and DEC (op 7) gives A-1. Both set auxiliary carry, overflow, parity, zero and sign, and copy carry from the flag register.
- R7: NEG (op 8) gives 0-A. Carry is set when A is non-zero, and overflow is set when A is the most negative value of the width.
- R8: SHL (op 10) and SHR (op 11) shift by one and fill the vacated bit with 0. Carry receives the bit shifted out and auxiliary carry is 0. Overflow is the new top bit XOR the new carry on a left shift; on SHR it is the original top bit.
- R9: ROL (op 12) and ROR (op 13) rotate by one within the width. RCL (op 14) and RCR (op 15) rotate through the stored carry. Carry receives the bit moved out. Overflow is the new top bit XOR carry for left rotates, and the XOR of the two top result bits for right rotates. Parity, auxiliary, zero and sign keep the flag register's values.
- R10: The flag register clears to 0 when `rst_n` is low at a clock edge. It loads `flags_o` on an edge with `flag_we_i` high and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 4 | Operation code |
| word_i | input | 1 | 1 selects 16-bit word, 0 selects 8-bit byte |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| flag_we_i | input | 1 | Load flags into the flag register at the next edge |
| res_o | output | 16 | Result, combinational |
| flags_o | output | 6 | Flags computed for the current inputs |
| flag_reg_o | output | 6 | Stored flag register |

## Verification
The embedded assertions check several properties on every cycle:
- the zero upper byte in byte mode;
- zero and sign against the result on non-rotate operations;
- the unchanged operand on compare;
- the cleared flags on logic operations;
- the carry kept by increment and decrement;
- the carry of negate;
- the flags held by rotates;
- the load and hold of the flag register.

The exact arithmetic values can only be shown by the bench's sweeps. These include carry, borrow and auxiliary carry across the nibble and width boundaries, signed overflow at the corner operands, parity, and the bit pulled in by rotates through a stored carry. The bench sweeps every byte operand against a set of boundary values for every operation, then covers word corners and pseudo-random words.

// File: rtl/bw_alu_pkg.sv
// Package: shared operation codes and flag bit positions for the byte/word ALU.
// Assumes a 4-bit operation code; the flag vector order is fixed and decoded by neighbours.
package bw_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_OR  = 4'd3,
        OP_XOR = 4'd4,
        OP_NOT = 4'd5,
        OP_INC = 4'd6,
        OP_DEC = 4'd7,
        OP_NEG = 4'd8,
        OP_CMP = 4'd9,
        OP_SHL = 4'd10,
        OP_SHR = 4'd11,
        OP_ROL = 4'd12,
        OP_ROR = 4'd13,
        OP_RCL = 4'd14,
        OP_RCR = 4'd15
    } alu_op_e;

    localparam int FLAG_N = 6;
    localparam int FL_CF  = 0;
    localparam int FL_PF  = 1;
    localparam int FL_AF  = 2;
    localparam int FL_ZF  = 3;
    localparam int FL_SF  = 4;
    localparam int FL_OF  = 5;

endpackage

// File: rtl/bw_addsub.sv
// Module: width-aware adder. Computes x + y + cin and reports raw carries.
// Assumes subtraction is presented as x + ~y + 1 by the caller, which inverts
// the carries into borrows. Upper bits of the sum are garbage in byte mode.
module bw_addsub #(
    parameter int W   = 16,
    parameter int H   = 8,
    parameter int NIB = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    input  logic         narrow,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         c4,
    output logic         ovf
);

    logic [W:0]   full;
    logic [W-1:0] cin_vec;

    // Purpose: one full-width addition; carries into each bit recovered by XOR.
    always_comb begin
        full    = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
        sum     = full[W-1:0];
        cin_vec = x ^ y ^ full[W-1:0];
    end

    // Purpose: select the carry out and signed overflow for the active width.
    always_comb begin
        c4 = cin_vec[NIB];
        if (narrow) begin
            cout = cin_vec[H];
            ovf  = (x[H-1] == y[H-1]) && (full[H-1] != x[H-1]);
        end else begin
            cout = full[W];
            ovf  = (x[W-1] == y[W-1]) && (full[W-1] != x[W-1]);
        end
    end

endmodule

// File: rtl/bw_shifter.sv
// Module: one-position shifter/rotator for byte or word width.
// Assumes v is already masked to the active width (upper byte zero in byte mode).
module bw_shifter #(
    parameter int W = 16,
    parameter int H = 8
) (
    input  logic [W-1:0] v,
    input  logic         narrow,
    input  logic         left,
    input  logic         rotate,
    input  logic         thru,
    input  logic         cf_in,
    output logic [W-1:0] res,
    output logic         cout,
    output logic         ovf
);

    localparam logic [W-1:0] TOP_WORD  = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] TOP_BYTE  = {{(W-H){1'b0}}, 1'b1, {(H-1){1'b0}}};
    localparam logic [W-1:0] MASK_BYTE = {{(W-H){1'b0}}, {H{1'b1}}};

    logic msb_in;
    logic fill;
    logic new_top;
    logic new_next;

    // Purpose: choose the incoming bit and form the shifted value.
    always_comb begin
        msb_in = narrow ? v[H-1] : v[W-1];
        if (rotate) begin
            fill = thru ? cf_in : (left ? msb_in : v[0]);
        end else begin
            fill = 1'b0;
        end
        if (left) begin
            res  = ((v << 1) | {{(W-1){1'b0}}, fill}) & (narrow ? MASK_BYTE : '1);
            cout = msb_in;
        end else begin
            res  = (v >> 1) | (fill ? (narrow ? TOP_BYTE : TOP_WORD) : '0);
            cout = v[0];
        end
    end

    // Purpose: overflow from the top of the new value.
    always_comb begin
        new_top  = narrow ? res[H-1] : res[W-1];
        new_next = narrow ? res[H-2] : res[W-2];
        ovf      = left ? (new_top ^ cout) : (new_top ^ new_next);
    end

endmodule

// File: rtl/bw_flag_gen.sv
// Module: result-derived status bits: parity of the low byte, zero and sign
// for the active width. Assumes the upper byte of res is zero in byte mode.
module bw_flag_gen #(
    parameter int W     = 16,
    parameter int H     = 8,
    parameter int PAR_W = 8
) (
    input  logic [W-1:0] res,
    input  logic         narrow,
    output logic         pf,
    output logic         zf,
    output logic         sf
);

    // Purpose: derive parity, zero and sign from the result.
    always_comb begin
        pf = ~^res[PAR_W-1:0];
        zf = narrow ? (res[H-1:0] == '0) : (res == '0);
        sf = narrow ? res[H-1] : res[W-1];
    end

endmodule

// File: rtl/bw_alu.sv
// Module: byte/word ALU with a six-bit flag register.
// Result and flags are combinational from the inputs and the stored flags; the
// flag register loads on flag_we_i. Assumes DATA_W = 2 * BYTE_W and BYTE_W >= 8.
module bw_alu
    import bw_alu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_i,
    input  logic              word_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              flag_we_i,
    output logic [DATA_W-1:0] res_o,
    output logic [FLAG_N-1:0] flags_o,
    output logic [FLAG_N-1:0] flag_reg_o
);

    localparam int NIB_W = BYTE_W / 2;
    localparam logic [DATA_W-1:0] BYTE_MASK = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
    localparam logic [DATA_W-1:0] ONE       = {{(DATA_W-1){1'b0}}, 1'b1};

    alu_op_e           op;
    logic              narrow;
    logic [DATA_W-1:0] wmask, a_m, b_m;
    logic              is_arith, is_sub, is_logic, is_shift, is_rot, keep_cf;
    logic [DATA_W-1:0] ax, ay, sum, sh_res, flag_src;
    logic              acin, a_cout, a_c4, a_ovf;
    logic              sh_cout, sh_ovf;
    logic              g_pf, g_zf, g_sf;

    assign op     = alu_op_e'(op_i);
    assign narrow = ~word_i;
    assign wmask  = narrow ? BYTE_MASK : '1;
    assign a_m    = a_i & wmask;
    assign b_m    = b_i & wmask;

    // Purpose: classify the operation into flag-rule groups.
    always_comb begin
        is_arith = op inside {OP_ADD, OP_SUB, OP_CMP, OP_INC, OP_DEC, OP_NEG};
        is_sub   = op inside {OP_SUB, OP_CMP, OP_DEC, OP_NEG};
        is_logic = op inside {OP_AND, OP_OR, OP_XOR, OP_NOT};
        is_shift = op inside {OP_SHL, OP_SHR};
        is_rot   = op inside {OP_ROL, OP_ROR, OP_RCL, OP_RCR};
        keep_cf  = op inside {OP_INC, OP_DEC};
    end

    // Purpose: present adder operands; subtraction as x + ~y + 1.
    always_comb begin
        ax   = a_m;
        ay   = b_m;
        acin = 1'b0;
        unique case (op)
            OP_SUB, OP_CMP: begin ay = ~b_m; acin = 1'b1; end
            OP_INC:         begin ay = ONE;  acin = 1'b0; end
            OP_DEC:         begin ay = ~ONE; acin = 1'b1; end
            OP_NEG:         begin ax = '0; ay = ~a_m; acin = 1'b1; end
            default:        begin ax = a_m; ay = b_m; acin = 1'b0; end
        endcase
    end

    bw_addsub #(.W(DATA_W), .H(BYTE_W), .NIB(NIB_W)) i_addsub (
        .x(ax), .y(ay), .cin(acin), .narrow(narrow),
        .sum(sum), .cout(a_cout), .c4(a_c4), .ovf(a_ovf)
    );

    bw_shifter #(.W(DATA_W), .H(BYTE_W)) i_shifter (
        .v(a_m), .narrow(narrow),
        .left(op inside {OP_SHL, OP_ROL, OP_RCL}),
        .rotate(is_rot),
        .thru(op inside {OP_RCL, OP_RCR}),
        .cf_in(flag_reg_o[FL_CF]),
        .res(sh_res), .cout(sh_cout), .ovf(sh_ovf)
    );

    // Purpose: select the visible result for the operation.
    always_comb begin
        unique case (op)
            OP_AND:  res_o = a_m & b_m;
            OP_OR:   res_o = a_m | b_m;
            OP_XOR:  res_o = a_m ^ b_m;
            OP_NOT:  res_o = ~a_m & wmask;
            OP_CMP:  res_o = a_m;
            default: res_o = (is_shift || is_rot) ? sh_res : (sum & wmask);
        endcase
        flag_src = (op == OP_CMP) ? (sum & wmask) : res_o;
    end

    bw_flag_gen #(.W(DATA_W), .H(BYTE_W), .PAR_W(8)) i_flag_gen (
        .res(flag_src), .narrow(narrow), .pf(g_pf), .zf(g_zf), .sf(g_sf)
    );

    // Purpose: assemble the flag vector by operation group.
    always_comb begin
        flags_o        = '0;
        flags_o[FL_PF] = g_pf;
        flags_o[FL_ZF] = g_zf;
        flags_o[FL_SF] = g_sf;
        if (is_arith) begin
            flags_o[FL_CF] = keep_cf ? flag_reg_o[FL_CF] : (a_cout ^ is_sub);
            flags_o[FL_AF] = a_c4 ^ is_sub;
            flags_o[FL_OF] = a_ovf;
        end else if (is_shift) begin
            flags_o[FL_CF] = sh_cout;
            flags_o[FL_OF] = sh_ovf;
        end else if (is_rot) begin
            flags_o        = flag_reg_o;
            flags_o[FL_CF] = sh_cout;
            flags_o[FL_OF] = sh_ovf;
        end
    end

    // Purpose: flag register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_reg_o <= '0;
        end else if (flag_we_i) begin
            flag_reg_o <= flags_o;
        end
    end

    // R1: byte mode never drives the upper result byte.
    p_byte_upper_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !word_i |-> res_o[DATA_W-1:BYTE_W] == '0);
    // R2: zero flag agrees with the visible result outside compare and rotates.
    p_zero_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_rot && op != OP_CMP) |-> flags_o[FL_ZF] == (res_o == '0));
    // R2: sign flag is the top bit of the active width of the result.
    p_sign_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_rot && op != OP_CMP) |->
            flags_o[FL_SF] == (word_i ? res_o[DATA_W-1] : res_o[BYTE_W-1]));
    // R4: compare leaves the first operand on the result port.
    p_cmp_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_CMP |-> res_o == (word_i ? a_i : (a_i & BYTE_MASK)));
    // R5: logic operations clear carry, auxiliary carry and overflow.
    p_logic_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        is_logic |-> !flags_o[FL_CF] && !flags_o[FL_AF] && !flags_o[FL_OF]);
    // R6: increment and decrement carry the stored carry through.
    p_incdec_cf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        keep_cf |-> flags_o[FL_CF] == flag_reg_o[FL_CF]);
    // R7: negate borrows exactly when the operand is non-zero.
    p_neg_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_NEG |-> flags_o[FL_CF] == (a_m != '0));
    // R9: rotates keep parity, auxiliary, zero and sign from the register.
    p_rot_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        is_rot |-> flags_o[FL_SF:FL_PF] == flag_reg_o[FL_SF:FL_PF]);
    // R10: register holds without a write enable.
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we_i |=> $stable(flag_reg_o));
    // R10: register captures the computed flags on a write enable.
    p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we_i |=> flag_reg_o == $past(flags_o));

endmodule

// File: tb/test_bw_alu.sv
// Bench: sweeps every byte operand against boundary values for all operations,
// then word corners and pseudo-random words; a reference model tracks the flag register.
module test_bw_alu;

    localparam int PERIOD   = 10;
    localparam int WD_LIMIT = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = 4'd0;
    logic        word_i = 1'b0;
    logic [15:0] a_i = '0, b_i = '0;
    logic        flag_we_i = 1'b0;
    logic [15:0] res_o;
    logic [5:0]  flags_o, flag_reg_o;

    int          n_run = 0, n_fail = 0;
    logic [5:0]  model_reg = '0;
    int          step_cnt = 0;
    bit          done = 1'b0;

    bw_alu i_bw_alu (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .word_i(word_i),
        .a_i(a_i), .b_i(b_i), .flag_we_i(flag_we_i),
        .res_o(res_o), .flags_o(flags_o), .flag_reg_o(flag_reg_o)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic string tag_of(input int op);
        case (op)
            0:             return "R3";
            1, 9:          return "R4";
            2, 3, 4, 5:    return "R5";
            6, 7:          return "R6";
            8:             return "R7";
            10, 11:        return "R8";
            default:       return "R9";
        endcase
    endfunction

    // Reference: returns {flags[5:0], result[15:0]} from R1-style width rules.
    function automatic logic [21:0] model(input int op, input int a, input int b,
                                          input bit word, input logic [5:0] freg);
        int w = word ? 16 : 8;
        int mask = (1 << w) - 1;
        int av = a & mask;
        int bv = b & mask;
        int sb = 1 << (w - 1);
        int r = 0, rm, nb;
        bit cf = 0, af = 0, of = 0, pf, zf, sf, keep = 0, c;
        int shown;
        case (op)
            0: begin r = av + bv; cf = ((r >> w) & 1) != 0;
                     af = (((av & 15) + (bv & 15)) >> 4) != 0;
                     of = ((av & sb) == (bv & sb)) && ((r & sb) != (av & sb)); end
            1, 9: begin r = av - bv; cf = av < bv; af = (av & 15) < (bv & 15);
                     of = ((av & sb) != (bv & sb)) && ((r & sb) != (av & sb)); end
            2: r = av & bv;
            3: r = av | bv;
            4: r = av ^ bv;
            5: r = ~av;
            6: begin r = av + 1; cf = freg[0]; af = (av & 15) == 15; of = av == sb - 1; end
            7: begin r = av - 1; cf = freg[0]; af = (av & 15) == 0;  of = av == sb; end
            8: begin r = 0 - av; cf = av != 0; af = (av & 15) != 0; of = av == sb; end
            10: begin r = av << 1; cf = (av & sb) != 0; of = ((r & sb) != 0) ^ cf; end
            11: begin r = av >> 1; cf = (av & 1) != 0; of = (av & sb) != 0; end
            12: begin cf = (av & sb) != 0; r = (av << 1) | int'(cf);
                      of = ((r & sb) != 0) ^ cf; keep = 1; end
            13: begin cf = (av & 1) != 0; r = (av >> 1) | (cf ? sb : 0);
                      of = ((r & sb) != 0) ^ ((r & (sb >> 1)) != 0); keep = 1; end
            14: begin c = freg[0]; r = (av << 1) | int'(c); cf = (av & sb) != 0;
                      of = ((r & sb) != 0) ^ cf; keep = 1; end
            default: begin c = freg[0]; r = (av >> 1) | (c ? sb : 0); cf = (av & 1) != 0;
                      of = ((r & sb) != 0) ^ ((r & (sb >> 1)) != 0); keep = 1; end
        endcase
        rm = r & mask;
        zf = rm == 0;
        sf = (rm & sb) != 0;
        nb = 0;
        for (int i = 0; i < 8; i++) nb += (rm >> i) & 1;
        pf = (nb % 2) == 0;
        if (keep) begin
            pf = freg[1]; af = freg[2]; zf = freg[3]; sf = freg[4];
        end
        shown = (op == 9) ? av : rm;
        return {of, sf, zf, af, pf, cf, shown[15:0]};
    endfunction

    // One operation: drive, check combinational outputs mid-cycle, clock, check register.
    task automatic step(input int op, input int a, input int b, input bit word);
        logic [21:0] exp;
        bit we;
        string tg;
        we = (step_cnt % 4) != 3;
        step_cnt++;
        op_i = op[3:0]; a_i = a[15:0]; b_i = b[15:0]; word_i = word; flag_we_i = we;
        tg = word ? tag_of(op) : {"R1/", tag_of(op)};
        @(negedge clk);
        exp = model(op, a, b, word, model_reg);
        n_run++;
        if (res_o !== exp[15:0]) begin
            n_fail++;
            $display("FAIL %s result op=%0d a=%h b=%h: got %h exp %h", tg, op, a_i, b_i, res_o, exp[15:0]);
        end
        n_run++;
        if (flags_o !== exp[21:16]) begin
            n_fail++;
            $display("FAIL R2/%s flags op=%0d a=%h b=%h freg=%b: got %b exp %b",
                     tg, op, a_i, b_i, model_reg, flags_o, exp[21:16]);
        end
        @(posedge clk); #1;
        if (we) model_reg = exp[21:16];
        n_run++;
        if (flag_reg_o !== model_reg) begin
            n_fail++;
            $display("FAIL R10 flag register we=%0b: got %b exp %b", we, flag_reg_o, model_reg);
        end
    endtask

    function automatic int bval(input int k);
        case (k)
            0: return 16'hA500; 1: return 16'h3C01; 2: return 16'h000F; 3: return 16'hFF10;
            4: return 16'h007F; 5: return 16'h1280; 6: return 16'h00FF; default: return 16'hE75A;
        endcase
    endfunction

    function automatic int wcorner(input int k);
        case (k)
            0: return 16'h0000; 1: return 16'h0001; 2: return 16'h000F;
            3: return 16'h7FFF; 4: return 16'h8000; default: return 16'hFFFF;
        endcase
    endfunction

    initial begin : watchdog
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired after %0d cycles: got no finish exp finish", WD_LIMIT);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        int seed;
        seed = 32'h1D2C3B4A;
        // R10: reset dominates a pending write enable.
        flag_we_i = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        n_run++;
        if (flag_reg_o !== 6'b0) begin
            n_fail++;
            $display("FAIL R10 reset value: got %b exp %b", flag_reg_o, 6'b0);
        end
        rst_n = 1'b1;
        model_reg = '0;

        // R1..R9: byte mode, every low-byte operand, upper bytes deliberately non-zero.
        for (int op = 0; op < 16; op++)
            for (int a = 0; a < 256; a++)
                for (int k = 0; k < 8; k++)
                    step(op, a | ((a * 37) << 8), bval(k), 1'b0);

        // Word corners: carry, borrow, nibble and signed boundaries.
        for (int op = 0; op < 16; op++)
            for (int x = 0; x < 6; x++)
                for (int y = 0; y < 6; y++)
                    step(op, wcorner(x), wcorner(y), 1'b1);

        // Pseudo-random words.
        for (int op = 0; op < 16; op++)
            for (int k = 0; k < 1500; k++) begin
                int ra, rb;
                seed = seed ^ (seed << 13); seed = seed ^ (seed >>> 17); seed = seed ^ (seed << 5);
                ra = seed & 16'hFFFF;
                rb = (seed >>> 16) & 16'hFFFF;
                step(op, ra, rb, 1'b1);
            end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule